// File: doc/BRIEF.md
# Microcode Image Validator and Loader

This block takes a firmware image held in a word-addressed, read-only image memory and moves it into the processor subsystem. It does this in two passes. In the first pass it checks the header and sizes the image from its per-processor descriptors. It then runs a CRC-32 over every byte ahead of the trailing checksum word. The second pass starts only when every check has succeeded. In that pass, for each processor, it sends the instruction RAM start address (with the auto-increment flag set) and then the code words. It also programs the nonzero trap entries and the trap-enable register.

A single start pulse launches a run. `busy` stays high until the cycle in which either a one-cycle `done` or a one-cycle `err` (with a cause code) appears. All writes leave through one registered write port. A select field on that port tells which target register or RAM port receives the data. The image layout uses fixed word offsets. Word 0 holds the three magic bytes in bits [31:8] and the version in bits [7:0]. Word 1 holds the declared length in bytes. In word 2, bits [31:24] hold the processor count and bits [23:16] hold the split flag. Descriptors start at word 3 and take 4+NUM_TRAPS words each: code offset (a word index, 0 = no code), code word count, instruction RAM start address, trap-enable value, then the trap entries in index order.

Top module: `ucode_loader`

## Requirements
- R1: A word 0 whose bits [31:8] differ from 0x514546 ends the run with `err` and `err_code` 1.
- R2: With a correct magic, a version byte (word 0 bits [7:0]) other than 1 ends the run with `err_code` 2.
- R3: A processor count (word 2 bits [31:24]) of 0 or above MAX_PROC ends the run with `err_code` 3.
- R4: The declared length (word 1) must equal 4*(3 + count*(4+NUM_TRAPS) + sum of code counts) + 4. Otherwise the run ends with `err_code` 4.
- R5: The word right after the sized image must equal a CRC-32 with reflected polynomial 0xEDB88320, initial value 0 and no final inversion. That CRC is taken over all earlier bytes, most significant byte of each word first. A mismatch gives `err_code` 5. On any error no write at all is issued.
- R6: When the split flag byte is zero, one write with select 4 and data 1 is issued before any instruction RAM write. When the byte is nonzero, no such write is issued.
- R7: For each processor with a nonzero code offset, these writes are issued in order. First comes a select 0 write carrying the start address with bit 31 set. Then come `count` writes with select 1 carrying image words offset, offset+1, and so on. A zero offset gives no select 0 or 1 write.
- R8: Per processor, in ascending processor order, every nonzero trap entry is written with select 2 and its index on `wr_idx`, in index order. Zero entries are skipped. After the trap entries, a select 3 write carries the trap-enable value. The last such write shares its cycle with `done`.
- R9: `busy` rises in the cycle after an accepted start and is low in the cycle where `done` or `err` pulses. A start while busy is ignored. A start in the `done` cycle is accepted.
- R10: After reset `busy`, `done`, `err`, `wr_en`, `img_rd` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 3 | 0 none, 1 magic, 2 version, 3 count, 4 length, 5 CRC; held until the next start |
| img_rd | output | 1 | Image read strobe |
| img_addr | output | AW | Image word address |
| img_rdata | input | 32 | Image data, valid one cycle after the strobe |
| wr_en | output | 1 | Write strobe |
| wr_sel | output | 3 | 0 RAM address, 1 RAM data, 2 trap, 3 trap enable, 4 RAM merge |
| wr_proc | output | PW | Target processor |
| wr_idx | output | TW | Trap index (0 for other selects) |
| wr_data | output | 32 | Write data |

## Verification
Two functions can land in the same cycle. The final trap-enable write of the last processor is issued together with the `done` pulse. A fresh start can also arrive in that very `done` cycle. The bench looks for the select 3 write in every `done` cycle. In one case it raises `start` in the sampled `done` cycle and expects the second run to begin with `busy` in the next cycle and to replay an identical write stream. Starts injected mid-run must leave the write stream unchanged.

// File: rtl/mcl_pkg.sv
package mcl_pkg;
    localparam logic [23:0] IMG_MAGIC   = 24'h514546;
    localparam logic [7:0]  IMG_VERSION = 8'd1;
    localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
    localparam logic [31:0] AUTO_INC    = 32'h8000_0000;
    localparam int          HDR_WORDS   = 3;
    localparam int          DESC_FIXED  = 4;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_MAGIC   = 3'd1,
        ERR_VERSION = 3'd2,
        ERR_COUNT   = 3'd3,
        ERR_LENGTH  = 3'd4,
        ERR_CRC     = 3'd5
    } err_e;

    typedef enum logic [2:0] {
        WS_IADDR = 3'd0,
        WS_IDATA = 3'd1,
        WS_TRAP  = 3'd2,
        WS_TEN   = 3'd3,
        WS_MERGE = 3'd4
    } wsel_e;

    typedef enum logic [3:0] {
        S_IDLE, S_HDR, S_SUM, S_CRC, S_DESC, S_CODE, S_TRAP, S_TEN
    } ld_state_e;
endpackage

// File: rtl/mcl_crc_byte.sv
module mcl_crc_byte
    import mcl_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  data_in,
    output logic [31:0] crc_out
);
    always_comb begin
        logic [31:0] c;
        c = crc_in ^ {24'h0, data_in};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
        end
        crc_out = c;
    end
endmodule

// File: rtl/mcl_hdr_check.sv
module mcl_hdr_check
    import mcl_pkg::*;
#(
    parameter int MAX_PROC = 4
) (
    input  logic [31:0] word,
    input  logic [1:0]  which,
    output err_e        code
);
    always_comb begin
        code = ERR_NONE;
        if (which == 2'd0) begin
            if (word[31:8] != IMG_MAGIC)
                code = ERR_MAGIC;
            else if (word[7:0] != IMG_VERSION)
                code = ERR_VERSION;
        end else if (which == 2'd2) begin
            if (word[31:24] == 8'd0 || word[31:24] > 8'(MAX_PROC))
                code = ERR_COUNT;
        end
    end
endmodule

// File: rtl/mcl_size_calc.sv
module mcl_size_calc
    import mcl_pkg::*;
#(
    parameter int DESC_WORDS = 20
) (
    input  logic [7:0]  cnt,
    input  logic [31:0] sum,
    input  logic [31:0] len,
    output logic [31:0] size_w,
    output logic        len_ok
);
    assign size_w = 32'(HDR_WORDS) + 32'(cnt) * 32'(DESC_WORDS) + sum;
    assign len_ok = ({2'b00, len} == ({size_w, 2'b00} + 34'd4));
endmodule

// File: rtl/ucode_loader.sv
module ucode_loader
    import mcl_pkg::*;
#(
    parameter int AW        = 10,
    parameter int MAX_PROC  = 4,
    parameter int NUM_TRAPS = 16,
    localparam int PW = (MAX_PROC > 1) ? $clog2(MAX_PROC) : 1,
    localparam int TW = (NUM_TRAPS > 1) ? $clog2(NUM_TRAPS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [2:0]    err_code,
    output logic          img_rd,
    output logic [AW-1:0] img_addr,
    input  logic [31:0]   img_rdata,
    output logic          wr_en,
    output logic [2:0]    wr_sel,
    output logic [PW-1:0] wr_proc,
    output logic [TW-1:0] wr_idx,
    output logic [31:0]   wr_data
);
    localparam int DESC_WORDS = DESC_FIXED + NUM_TRAPS;

    typedef struct packed {
        ld_state_e     st;
        logic [1:0]    ph;
        logic          rd;
        logic [AW-1:0] addr;
        logic [31:0]   widx;
        logic [PW:0]   p;
        logic [7:0]    cnt;
        logic          split;
        logic [31:0]   len;
        logic [31:0]   sum;
        logic [31:0]   size;
        logic [31:0]   crc;
        logic [31:0]   word;
        logic [1:0]    bcnt;
        logic [AW-1:0] off;
        logic          offnz;
        logic [31:0]   ccount;
        logic          done;
        logic          err;
        err_e          code;
        logic          wr_en;
        wsel_e         wsel;
        logic [PW-1:0] wproc;
        logic [TW-1:0] wtidx;
        logic [31:0]   wdata;
    } regs_t;

    regs_t q, d;

    err_e          hdr_code;
    logic [31:0]   crc_nx;
    logic [31:0]   size_w;
    logic          len_ok;
    logic [AW-1:0] desc_base;

    mcl_hdr_check #(.MAX_PROC(MAX_PROC)) u_hdr (
        .word  (img_rdata),
        .which (q.widx[1:0]),
        .code  (hdr_code)
    );

    mcl_crc_byte u_crc (
        .crc_in  (q.crc),
        .data_in (q.word[31:24]),
        .crc_out (crc_nx)
    );

    mcl_size_calc #(.DESC_WORDS(DESC_WORDS)) u_size (
        .cnt    (q.cnt),
        .sum    (q.sum),
        .len    (q.len),
        .size_w (size_w),
        .len_ok (len_ok)
    );

    assign desc_base = AW'(HDR_WORDS + int'(q.p) * DESC_WORDS);

    function automatic regs_t put(regs_t r, wsel_e s, logic [TW-1:0] i, logic [31:0] v);
        r.wr_en = 1'b1;
        r.wsel  = s;
        r.wproc = r.p[PW-1:0];
        r.wtidx = i;
        r.wdata = v;
        return r;
    endfunction

    function automatic regs_t fail(regs_t r, err_e c);
        r.st   = S_IDLE;
        r.ph   = 2'd0;
        r.err  = 1'b1;
        r.code = c;
        return r;
    endfunction

    always_comb begin
        d       = q;
        d.rd    = 1'b0;
        d.done  = 1'b0;
        d.err   = 1'b0;
        d.wr_en = 1'b0;
        if (q.st != S_IDLE && q.ph == 2'd1) begin
            d.ph = 2'd2;
        end else begin
            case (q.st)
                S_IDLE: begin
                    if (start) begin
                        d.st   = S_HDR;
                        d.ph   = 2'd0;
                        d.widx = '0;
                        d.code = ERR_NONE;
                        d.sum  = '0;
                        d.p    = '0;
                        d.crc  = '0;
                    end
                end
                S_HDR: begin
                    if (q.ph == 2'd0) begin
                        d.addr = AW'(q.widx);
                        d.rd   = 1'b1;
                        d.ph   = 2'd1;
                    end else begin
                        d.ph   = 2'd0;
                        d.widx = q.widx + 32'd1;
                        case (q.widx[1:0])
                            2'd0: if (hdr_code != ERR_NONE) d = fail(d, hdr_code);
                            2'd1: d.len = img_rdata;
                            default: begin
                                d.cnt   = img_rdata[31:24];
                                d.split = |img_rdata[23:16];
                                if (hdr_code != ERR_NONE) begin
                                    d = fail(d, hdr_code);
                                end else begin
                                    d.st = S_SUM;
                                    d.p  = '0;
                                end
                            end
                        endcase
                    end
                end
                S_SUM: begin
                    if (q.ph == 2'd0) begin
                        if (8'(q.p) == q.cnt) begin
                            if (!len_ok) begin
                                d = fail(d, ERR_LENGTH);
                            end else begin
                                d.size = size_w;
                                d.st   = S_CRC;
                                d.widx = '0;
                            end
                        end else begin
                            d.addr = desc_base + AW'(1);
                            d.rd   = 1'b1;
                            d.ph   = 2'd1;
                        end
                    end else begin
                        d.sum = q.sum + img_rdata;
                        d.p   = q.p + 1'b1;
                        d.ph  = 2'd0;
                    end
                end
                S_CRC: begin
                    if (q.ph == 2'd0) begin
                        d.addr = AW'(q.widx);
                        d.rd   = 1'b1;
                        d.ph   = 2'd1;
                    end else if (q.ph == 2'd2) begin
                        if (q.widx == q.size) begin
                            if (img_rdata != q.crc) begin
                                d = fail(d, ERR_CRC);
                            end else begin
                                d.st   = S_DESC;
                                d.p    = '0;
                                d.widx = '0;
                                d.ph   = 2'd0;
                                if (!q.split) d = put(d, WS_MERGE, '0, 32'd1);
                            end
                        end else begin
                            d.word = img_rdata;
                            d.bcnt = 2'd0;
                            d.ph   = 2'd3;
                        end
                    end else begin
                        d.crc  = crc_nx;
                        d.word = {q.word[23:0], 8'h00};
                        d.bcnt = q.bcnt + 2'd1;
                        if (q.bcnt == 2'd3) begin
                            d.ph   = 2'd0;
                            d.widx = q.widx + 32'd1;
                        end
                    end
                end
                S_DESC: begin
                    if (q.ph == 2'd0) begin
                        d.addr = desc_base + AW'(q.widx);
                        d.rd   = 1'b1;
                        d.ph   = 2'd1;
                    end else begin
                        d.ph   = 2'd0;
                        d.widx = q.widx + 32'd1;
                        if (q.widx == 32'd0) begin
                            d.off   = img_rdata[AW-1:0];
                            d.offnz = |img_rdata;
                        end else if (q.widx == 32'd1) begin
                            d.ccount = img_rdata;
                        end else begin
                            d.widx = '0;
                            if (q.offnz) begin
                                d    = put(d, WS_IADDR, '0, img_rdata | AUTO_INC);
                                d.st = S_CODE;
                            end else begin
                                d.st = S_TRAP;
                            end
                        end
                    end
                end
                S_CODE: begin
                    if (q.ph == 2'd0) begin
                        if (q.widx == q.ccount) begin
                            d.st   = S_TRAP;
                            d.widx = '0;
                        end else begin
                            d.addr = q.off + AW'(q.widx);
                            d.rd   = 1'b1;
                            d.ph   = 2'd1;
                        end
                    end else begin
                        d      = put(d, WS_IDATA, '0, img_rdata);
                        d.widx = q.widx + 32'd1;
                        d.ph   = 2'd0;
                    end
                end
                S_TRAP: begin
                    if (q.ph == 2'd0) begin
                        if (q.widx == 32'(NUM_TRAPS)) begin
                            d.st   = S_TEN;
                            d.widx = '0;
                        end else begin
                            d.addr = desc_base + AW'(DESC_FIXED) + AW'(q.widx);
                            d.rd   = 1'b1;
                            d.ph   = 2'd1;
                        end
                    end else begin
                        if (img_rdata != 32'd0) d = put(d, WS_TRAP, TW'(q.widx), img_rdata);
                        d.widx = q.widx + 32'd1;
                        d.ph   = 2'd0;
                    end
                end
                S_TEN: begin
                    if (q.ph == 2'd0) begin
                        d.addr = desc_base + AW'(3);
                        d.rd   = 1'b1;
                        d.ph   = 2'd1;
                    end else begin
                        d      = put(d, WS_TEN, '0, img_rdata);
                        d.ph   = 2'd0;
                        d.widx = '0;
                        if (8'(q.p) + 8'd1 == q.cnt) begin
                            d.st   = S_IDLE;
                            d.done = 1'b1;
                        end else begin
                            d.p  = q.p + 1'b1;
                            d.st = S_DESC;
                        end
                    end
                end
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
    assign err      = q.err;
    assign err_code = q.code;
    assign img_rd   = q.rd;
    assign img_addr = q.addr;
    assign wr_en    = q.wr_en;
    assign wr_sel   = q.wsel;
    assign wr_proc  = q.wproc;
    assign wr_idx   = q.wtidx;
    assign wr_data  = q.wdata;
endmodule

// File: rtl/ucode_loader_chk.sv
module ucode_loader_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        img_rd,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [31:0] wr_data
);
    logic seen_ram;

    always_ff @(posedge clk) begin
        if (!rst_n)                                  seen_ram <= 1'b0;
        else if (start && !busy)                     seen_ram <= 1'b0;
        else if (wr_en && (wr_sel == 3'd0 || wr_sel == 3'd1)) seen_ram <= 1'b1;
    end

    assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));
    assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);
    assert_end_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> $past(busy));
    assert_read_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        img_rd |-> busy);
    assert_no_write_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !wr_en);
    assert_autoinc_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd0) |-> wr_data[31]);
    assert_trap_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd2) |-> (wr_data != 32'd0));
    assert_merge_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd4) |-> !seen_ram);
endmodule

bind ucode_loader ucode_loader_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .img_rd  (img_rd),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data)
);

// File: tb/ucode_loader_tb.sv
`timescale 1ns/1ps
module ucode_loader_tb;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        busy, done, err;
    logic [2:0]  err_code;
    logic        img_rd;
    logic [AW-1:0] img_addr;
    logic [31:0] img_rdata;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [1:0]  wr_proc;
    logic [3:0]  wr_idx;
    logic [31:0] wr_data;

    always #4 clk = ~clk;

    logic [31:0] mem [0:1023];
    always_ff @(posedge clk) if (img_rd) img_rdata <= mem[img_addr];

    ucode_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .img_rd(img_rd), .img_addr(img_addr),
        .img_rdata(img_rdata), .wr_en(wr_en), .wr_sel(wr_sel), .wr_proc(wr_proc),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    int vec = 0;
    int bad = 0;

    logic [2:0]  e_sel [0:255];
    logic [1:0]  e_proc[0:255];
    logic [3:0]  e_idx [0:255];
    logic [31:0] e_dat [0:255];
    int          e_n;
    logic [2:0]  e_code;
    logic [2:0]  o_sel [0:255];
    logic [1:0]  o_proc[0:255];
    logic [3:0]  o_idx [0:255];
    logic [31:0] o_dat [0:255];
    int          o_n;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int nw);
        logic [31:0] c = 32'h0;
        for (int w = 0; w < nw; w++) begin
            for (int b = 3; b >= 0; b--) begin
                c = c ^ {24'h0, mem[w][b*8 +: 8]};
                for (int k = 0; k < 8; k++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
        end
        return c;
    endfunction

    task automatic add_exp(input logic [2:0] s, input int p, input int i, input logic [31:0] v);
        if (e_n < 256) begin
            e_sel[e_n] = s; e_proc[e_n] = 2'(p); e_idx[e_n] = 4'(i); e_dat[e_n] = v;
        end
        e_n++;
    endtask

    task automatic model();
        int n, sum, sz, base;
        e_n = 0;
        if (mem[0][31:8] != 24'h514546) e_code = 3'd1;
        else if (mem[0][7:0] != 8'd1) e_code = 3'd2;
        else begin
            n = int'(mem[2][31:24]);
            if (n < 1 || n > 4) e_code = 3'd3;
            else begin
                sum = 0;
                for (int p = 0; p < n; p++) sum += int'(mem[3 + 20*p + 1]);
                sz = 3 + 20*n + sum;
                if (mem[1] != 32'(sz*4 + 4)) e_code = 3'd4;
                else if (ref_crc(sz) != mem[sz]) e_code = 3'd5;
                else begin
                    e_code = 3'd0;
                    if (mem[2][23:16] == 8'd0) add_exp(3'd4, 0, 0, 32'd1);
                    for (int p = 0; p < n; p++) begin
                        base = 3 + 20*p;
                        if (mem[base] != 32'd0) begin
                            add_exp(3'd0, p, 0, mem[base+2] | 32'h8000_0000);
                            for (int i = 0; i < int'(mem[base+1]); i++)
                                add_exp(3'd1, p, 0, mem[int'(mem[base]) + i]);
                        end
                        for (int j = 0; j < 16; j++)
                            if (mem[base+4+j] != 32'd0) add_exp(3'd2, p, j, mem[base+4+j]);
                        add_exp(3'd3, p, 0, mem[base+3]);
                    end
                end
            end
        end
    endtask

    task automatic build_image(input int cnt, input bit split, input int corrupt,
                               input bit zero_traps, input bit zero_off0);
        int cursor, sum, base, cc, off, sz;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        mem[0] = {8'h51, 8'h45, 8'h46, 8'h01};
        cursor = 3 + 20*cnt;
        sum = 0;
        for (int p = 0; p < cnt; p++) begin
            base = 3 + 20*p;
            cc   = $urandom_range(0, 6);
            off  = cursor;
            if ((zero_off0 && p == 0) || $urandom_range(0, 3) == 0) begin
                off = 0; cc = 0;
            end
            mem[base]   = 32'(off);
            mem[base+1] = 32'(cc);
            mem[base+2] = $urandom & 32'h0000_FFFF;
            mem[base+3] = $urandom;
            for (int j = 0; j < 16; j++)
                mem[base+4+j] = (zero_traps || $urandom_range(0, 1) == 0) ? 32'h0 : ($urandom | 32'h1);
            for (int i = 0; i < cc; i++) mem[off+i] = $urandom;
            cursor += cc;
            sum += cc;
        end
        mem[2] = {8'(cnt), (split ? 8'h01 : 8'h00), 16'h0};
        sz = 3 + 20*cnt + sum;
        mem[1] = 32'(sz*4 + 4);
        mem[sz] = ref_crc(sz);
        case (corrupt)
            1: mem[0][23:16] = 8'h58;
            2: mem[0][7:0] = 8'd2;
            3: mem[2][31:24] = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'(5 + $urandom_range(0, 2));
            4: mem[1] = mem[1] + 32'd4;
            5: mem[7 + $urandom_range(0, 15)] ^= 32'h0000_0100;
            default: ;
        endcase
    endtask

    task automatic do_run(input bit poke, input bit pre, input bit chain_next);
        bit fin = 0;
        int cyc = 0;
        logic [2:0] g_code;
        string tag;
        model();
        o_n = 0;
        if (!pre) begin
            @(negedge clk); start = 1'b1;
        end
        @(negedge clk); start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
        while (!fin) begin
            if (wr_en) begin
                if (o_n < 256) begin
                    o_sel[o_n] = wr_sel; o_proc[o_n] = wr_proc;
                    o_idx[o_n] = wr_idx; o_dat[o_n] = wr_data;
                end
                o_n++;
            end
            if (done || err) begin
                fin = 1;
                g_code = err ? err_code : 3'd0;
                chk(busy === 1'b0, "R9", "busy low in end cycle", 32'(busy), 32'd0);
                if (done)
                    chk(wr_en && wr_sel == 3'd3, "R8", "enable write beside done",
                        {28'h0, wr_en, wr_sel}, 32'hB);
            end else begin
                cyc++;
                if (cyc > 20000) begin
                    chk(1'b0, "R9", "watchdog expired", 32'(cyc), 32'd0);
                    g_code = 3'd7;
                    fin = 1;
                end
            end
            if (fin && chain_next) start = 1'b1;
            else start = (poke && cyc == 6);
            if (!fin) @(negedge clk);
        end
        case (e_code)
            3'd1: tag = "R1";
            3'd2: tag = "R2";
            3'd3: tag = "R3";
            3'd4: tag = "R4";
            3'd5: tag = "R5";
            default: tag = "R7";
        endcase
        chk(g_code == e_code, tag, "outcome code", 32'(g_code), 32'(e_code));
        chk(o_n == e_n, (e_code != 3'd0) ? "R5" : "R7", "write count", 32'(o_n), 32'(e_n));
        for (int i = 0; i < e_n && i < o_n && i < 256; i++) begin
            string rq;
            rq = (e_sel[i] == 3'd4) ? "R6" : (e_sel[i] >= 3'd2) ? "R8" : "R7";
            chk(o_sel[i] == e_sel[i] && o_proc[i] == e_proc[i] && o_idx[i] == e_idx[i]
                && o_dat[i] == e_dat[i], rq, $sformatf("write %0d sel/proc/idx=%0d/%0d/%0d data", i,
                o_sel[i], o_proc[i], o_idx[i]), o_dat[i], e_dat[i]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, err, wr_en, img_rd} == 5'b0 && err_code == 3'd0, "R10",
            "outputs after reset", {26'h0, busy, done, err, wr_en, img_rd, 1'b0}, 32'h0);

        build_image(1, 1'b1, 0, 1'b0, 1'b0); do_run(1'b0, 1'b0, 1'b0);
        build_image(4, 1'b0, 0, 1'b0, 1'b0); do_run(1'b1, 1'b0, 1'b0);
        build_image(3, 1'b0, 0, 1'b1, 1'b1); do_run(1'b0, 1'b0, 1'b0);
        for (int c = 1; c <= 5; c++) begin
            build_image(2, 1'b0, c, 1'b0, 1'b0); do_run(1'b0, 1'b0, 1'b0);
        end
        build_image(2, 1'b1, 0, 1'b0, 1'b0);
        do_run(1'b0, 1'b0, 1'b1);
        do_run(1'b0, 1'b1, 1'b0);

        for (int r = 0; r < 25; r++) begin
            int k;
            k = $urandom_range(0, 9);
            build_image($urandom_range(1, 4), 1'($urandom_range(0, 1)), (k < 6) ? k : 0,
                        1'b0, 1'b0);
            do_run(1'($urandom_range(0, 1)), 1'b0, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule